// File: doc/BRIEF.md
# Redriver Link Power-State Controller

This block follows the link power state of a SuperSpeed USB redriver, using only registered status flags from the physical layer. Those flags are far-end termination presence and electrical idle for the upstream and the downstream port, a valid low-frequency periodic signalling (LFPS) indication, and a detection-complete strobe. The block decides whether the redriver is disconnected, fully active (U0), in shallow idle (U1) or in deep idle (U2/U3). For each of these states it drives the redrive, receiver-termination and transmitter common-mode enables.

In the two states where it must discover or re-confirm a far-end receiver, the block sends a single-cycle detect request at a fixed interval. The analog detector answers with its termination flags and a done strobe. Termination is evaluated only on that strobe. USB operation is allowed when a control pin or a control register bit is set. While neither is set, the block holds its lowest-power state.

Top module: `link_pwr_ctrl`

## Requirements
- R1: Synchronous reset, or having both enable inputs low, puts the block in Disconnect (state code 2'b00) on the next clock edge. The code is 2'b01 for U0, 2'b10 for U1 and 2'b11 for U2/U3.
- R2: In Disconnect, when `det_done` is high and both `term_up` and `term_dn` are high, the next state is U0. Otherwise the block stays in Disconnect.
- R3: In U0, when both `eidle_up` and `eidle_dn` are high, the next state is U1. Otherwise the block stays in U0.
- R4: In U1, if either electrical-idle flag is low or `lfps_ok` is high, the next state is U0.
- R5: Once in U1 with both ports idle and no LFPS, the block stays in U1 for exactly IDLE_CYCLES cycles and then enters U2/U3.
- R6: In U2/U3, a `det_done` pulse with either termination flag low sends the block to Disconnect. This rule wins over a simultaneous LFPS.
- R7: In U2/U3, `lfps_ok` high with no termination loss reported sends the block to U0. Otherwise the block stays in U2/U3.
- R8: The enables follow the state. Disconnect has all three low. U0 has redrive, termination and common mode high. U1 has termination and common mode high and redrive low. U2/U3 has only termination high.
- R9: `det_req` is a one-cycle pulse that repeats every DET_PERIOD cycles while the block is enabled and in Disconnect or U2/U3. It never rises in U0, in U1 or while the block is disabled.
- R10: Either enable input alone, the pin or the register bit, is enough to enable the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_en_pin | input | 1 | USB enable from the control pin |
| usb_en_reg | input | 1 | USB enable from the control register bit |
| term_up | input | 1 | Far-end termination present, upstream port |
| term_dn | input | 1 | Far-end termination present, downstream port |
| eidle_up | input | 1 | Electrical idle, upstream port |
| eidle_dn | input | 1 | Electrical idle, downstream port |
| lfps_ok | input | 1 | Valid LFPS seen |
| det_done | input | 1 | Detect result strobe; qualifies the term flags |
| state_o | output | 2 | Current link state code |
| redrive_en | output | 1 | Redrive enable, both ports |
| rx_term_en | output | 1 | Receiver termination enable |
| tx_cm_en | output | 1 | Transmitter DC common-mode enable |
| det_req | output | 1 | Far-end receiver detect request pulse |

## Verification
The hardest case to reach is U2/U3. Getting there takes a termination-confirmed detect, then idle on both ports, then an unbroken dwell of IDLE_CYCLES cycles. Only after that can the priority between termination loss and LFPS be exercised. The bench therefore resets and walks the block along that exact path before each trial. It then applies every combination of the six status inputs and both enable bits from each of the four states, and compares the result with a next-state rule computed in the bench. Dedicated runs measure the U1 dwell length and the spacing between detect pulses.

// File: rtl/link_pwr_pkg.sv
package link_pwr_pkg;

    typedef enum logic [1:0] {
        LS_DISC = 2'b00,
        LS_U0   = 2'b01,
        LS_U1   = 2'b10,
        LS_U23  = 2'b11
    } link_state_e;

    typedef struct packed {
        logic redrive;
        logic rx_term;
        logic tx_cm;
    } drive_set_t;

    typedef struct packed {
        logic term_up;
        logic term_dn;
        logic eidle_up;
        logic eidle_dn;
        logic lfps;
        logic done;
    } phy_flags_t;

    function automatic drive_set_t drive_for(link_state_e s);
        drive_set_t d;
        d.redrive = (s == LS_U0);
        d.rx_term = (s != LS_DISC);
        d.tx_cm   = (s == LS_U0) || (s == LS_U1);
        return d;
    endfunction

    function automatic logic polls_far_end(link_state_e s);
        return (s == LS_DISC) || (s == LS_U23);
    endfunction

endpackage

// File: rtl/lpc_period_timer.sv
module lpc_period_timer #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic pulse
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign pulse = run && (cnt == LAST);
endmodule

// File: rtl/lpc_dwell_timer.sv
module lpc_dwell_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic count_en,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !count_en)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expired = count_en && (cnt == LAST);
endmodule

// File: rtl/lpc_state_fsm.sv
module lpc_state_fsm
    import link_pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enabled,
    input  phy_flags_t  flags,
    input  logic        dwell_done,
    output link_state_e state
);
    link_state_e nxt;
    logic both_term, both_idle, term_lost;

    always_comb begin
        both_term = flags.term_up && flags.term_dn;
        both_idle = flags.eidle_up && flags.eidle_dn;
        term_lost = flags.done && !both_term;
        nxt = state;
        if (!enabled) begin
            nxt = LS_DISC;
        end else begin
            unique case (state)
                LS_DISC: if (flags.done && both_term) nxt = LS_U0;
                LS_U0:   if (both_idle) nxt = LS_U1;
                LS_U1: begin
                    if (!both_idle || flags.lfps) nxt = LS_U0;
                    else if (dwell_done)          nxt = LS_U23;
                end
                LS_U23: begin
                    if (term_lost)       nxt = LS_DISC;
                    else if (flags.lfps) nxt = LS_U0;
                end
                default: nxt = LS_DISC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LS_DISC;
        else     state <= nxt;
    end
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl
    import link_pwr_pkg::*;
#(
    parameter int DET_PERIOD  = 16,
    parameter int IDLE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       usb_en_pin,
    input  logic       usb_en_reg,
    input  logic       term_up,
    input  logic       term_dn,
    input  logic       eidle_up,
    input  logic       eidle_dn,
    input  logic       lfps_ok,
    input  logic       det_done,
    output logic [1:0] state_o,
    output logic       redrive_en,
    output logic       rx_term_en,
    output logic       tx_cm_en,
    output logic       det_req
);
    link_state_e cur;
    phy_flags_t  flags;
    drive_set_t  drv;
    logic        enabled, dwell_done, poll_run;

    assign enabled = usb_en_pin || usb_en_reg;
    assign flags   = '{term_up: term_up, term_dn: term_dn,
                       eidle_up: eidle_up, eidle_dn: eidle_dn,
                       lfps: lfps_ok, done: det_done};

    lpc_dwell_timer #(.LIMIT(IDLE_CYCLES)) u_dwell (
        .clk(clk), .rst(rst),
        .count_en(cur == LS_U1),
        .expired(dwell_done)
    );

    lpc_state_fsm u_fsm (
        .clk(clk), .rst(rst), .enabled(enabled),
        .flags(flags), .dwell_done(dwell_done), .state(cur)
    );

    assign poll_run = enabled && polls_far_end(cur);

    lpc_period_timer #(.PERIOD(DET_PERIOD)) u_poll (
        .clk(clk), .rst(rst), .run(poll_run), .pulse(det_req)
    );

    assign drv        = drive_for(cur);
    assign state_o    = cur;
    assign redrive_en = drv.redrive;
    assign rx_term_en = drv.rx_term;
    assign tx_cm_en   = drv.tx_cm;
endmodule

// File: rtl/link_pwr_ctrl_chk.sv
module link_pwr_ctrl_chk #(
    parameter int DET_PERIOD  = 16,
    parameter int IDLE_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       usb_en_pin,
    input logic       usb_en_reg,
    input logic       term_up,
    input logic       term_dn,
    input logic       eidle_up,
    input logic       eidle_dn,
    input logic       lfps_ok,
    input logic       det_done,
    input logic [1:0] state_o,
    input logic       redrive_en,
    input logic       rx_term_en,
    input logic       tx_cm_en,
    input logic       det_req
);
    localparam int DW = $clog2(IDLE_CYCLES + 2);
    logic en;
    logic [DW-1:0] u1_run;

    assign en = usb_en_pin || usb_en_reg;

    always_ff @(posedge clk) begin
        if (rst || state_o != 2'b10) u1_run <= '0;
        else if (u1_run != {DW{1'b1}}) u1_run <= u1_run + 1'b1;
    end

    // R1
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> state_o == 2'b00);

    // R2
    disc_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state_o == 2'b00 && det_done && term_up && term_dn) |=> state_o == 2'b01);

    // R3
    u0_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state_o == 2'b01 && eidle_up && eidle_dn) |=> state_o == 2'b10);

    // R5
    u1_dwell_limit_chk: assert property (@(posedge clk) disable iff (rst)
        32'(u1_run) <= IDLE_CYCLES);

    // R6
    u23_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state_o == 2'b11 && det_done && !(term_up && term_dn)) |=> state_o == 2'b00);

    // R7
    u23_lfps_chk: assert property (@(posedge clk) disable iff (rst)
        (en && state_o == 2'b11 && lfps_ok && !det_done) |=> state_o == 2'b01);

    // R8
    redrive_only_u0_chk: assert property (@(posedge clk) disable iff (rst)
        redrive_en |-> (rx_term_en && tx_cm_en));

    // R9
    det_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        det_req |=> !det_req);

    // R9
    det_req_state_chk: assert property (@(posedge clk) disable iff (rst)
        det_req |-> (en && (state_o == 2'b00 || state_o == 2'b11)));
endmodule

bind link_pwr_ctrl link_pwr_ctrl_chk #(
    .DET_PERIOD(DET_PERIOD), .IDLE_CYCLES(IDLE_CYCLES)
) u_chk (.*);

// File: tb/link_pwr_ctrl_test.sv
`timescale 1ns/1ps
module link_pwr_ctrl_test;
    localparam int P = 5;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_pin = 1'b0, en_reg = 1'b0;
    logic tu = 1'b0, td = 1'b0, eu = 1'b0, ed = 1'b0, lf = 1'b0, dd = 1'b0;
    logic [1:0] st;
    logic rd, rt, cm, dq;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    link_pwr_ctrl #(.DET_PERIOD(P), .IDLE_CYCLES(N)) uut (
        .clk(clk), .rst(rst), .usb_en_pin(en_pin), .usb_en_reg(en_reg),
        .term_up(tu), .term_dn(td), .eidle_up(eu), .eidle_dn(ed),
        .lfps_ok(lf), .det_done(dd), .state_o(st), .redrive_en(rd),
        .rx_term_en(rt), .tx_cm_en(cm), .det_req(dq)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_drive(input int s);
        // {redrive, rx_term, tx_cm}
        case (s)
            0: return 3'b000;
            1: return 3'b111;
            2: return 3'b011;
            default: return 3'b010;
        endcase
    endfunction

    function automatic int model_next(input int s, input int v, input int en);
        logic t_u, t_d, e_u, e_d, l, d;
        {t_u, t_d, e_u, e_d, l, d} = 6'(v);
        if (en == 0) return 0;
        case (s)
            0: return (d && t_u && t_d) ? 1 : 0;
            1: return (e_u && e_d) ? 1 + 1 : 1;
            2: return (!(e_u && e_d) || l) ? 1 : ((N == 1) ? 3 : 2);
            default: return (d && !(t_u && t_d)) ? 0 : (l ? 1 : 3);
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        {tu, td, eu, ed, lf, dd} = 6'b0;
        en_pin = 1'b1; en_reg = 1'b0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic goto_state(input int s);
        do_reset();
        if (s >= 1) begin
            dd = 1'b1; tu = 1'b1; td = 1'b1;
            step();
            dd = 1'b0;
        end
        if (s >= 2) begin
            eu = 1'b1; ed = 1'b1;
            step();
        end
        if (s == 3) repeat (N) step();
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        step();
        check("R1 reset state", int'(st), 0);
        check("R8 reset enables", int'({rd, rt, cm}), 0);

        // Sweep: each state x all flag combos x both enables
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 4; e++) begin
                for (int v = 0; v < 64; v++) begin
                    int en;
                    int nx;
                    goto_state(s);
                    check("R1/R2/R3/R5 path to state", int'(st), s);
                    {tu, td, eu, ed, lf, dd} = 6'(v);
                    en_pin = e[0]; en_reg = e[1];
                    en = (e != 0) ? 1 : 0;
                    nx = model_next(s, v, en);
                    step();
                    dd = 1'b0;
                    if (e == 1 || e == 2)
                        check("R10 single enable next state", int'(st), nx);
                    else if (s == 0)
                        check("R1 R2 disconnect next", int'(st), nx);
                    else if (s == 1)
                        check("R3 U0 next", int'(st), nx);
                    else if (s == 2)
                        check("R4 U1 next", int'(st), nx);
                    else
                        check("R6 R7 U2/U3 next", int'(st), nx);
                    check("R8 enables", int'({rd, rt, cm}), exp_drive(nx));
                end
            end
        end

        // R5 exact dwell in U1
        goto_state(2);
        for (int i = 1; i < N; i++) begin
            step();
            check("R5 still U1", int'(st), 2);
        end
        step();
        check("R5 U2/U3 after dwell", int'(st), 3);

        // R6 termination loss wins over LFPS
        goto_state(3);
        dd = 1'b1; tu = 1'b1; td = 1'b0; lf = 1'b1;
        step();
        dd = 1'b0; lf = 1'b0;
        check("R6 loss beats LFPS", int'(st), 0);

        // R9 detect pulse spacing in Disconnect and U2/U3
        for (int s = 0; s < 4; s += 3) begin
            int last;
            int seen;
            goto_state(s);
            last = -1; seen = 0;
            for (int c = 0; c < 4 * P; c++) begin
                if (dq) begin
                    if (last >= 0) check("R9 pulse period", c - last, P);
                    last = c; seen++;
                end
                step();
            end
            check("R9 pulse count", (seen >= 3) ? 1 : 0, 1);
            check("R9 state unchanged", int'(st), s);
        end

        // R9 no pulses in U0, U1 or disabled
        for (int s = 1; s < 3; s++) begin
            int seen;
            goto_state(s);
            seen = 0;
            for (int c = 0; c < ((s == 2) ? N - 1 : 3 * P); c++) begin
                seen += int'(dq);
                step();
            end
            check("R9 no pulse in U0/U1", seen, 0);
        end
        begin
            int seen;
            do_reset();
            en_pin = 1'b0; en_reg = 1'b0;
            seen = 0;
            for (int c = 0; c < 3 * P; c++) begin
                seen += int'(dq);
                step();
            end
            check("R9 no pulse while disabled", seen, 0);
            check("R1 disabled holds disconnect", int'(st), 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule